// File: doc/BRIEF.md
# Rename Register Pool Occupancy Tracker

This block keeps a running count of how many physical registers are in use in each of several rename pools. Pool 0 is the global pool, and every pool is charged for its own demand. The rename stage uses the count to decide whether a group of destination writes can be renamed in the current cycle.

In each cycle, the block takes a set of allocation lanes and a set of release lanes. Each lane carries a pool index, a cost in physical registers, and a flag. The flag marks writes that need no physical register, such as zero-idiom writes and eliminated moves. The block also takes a group of up to four query lanes. For that group it returns, in the same cycle, a bitmask with one bit for each pool that cannot accept the group.

The capacity of each pool is set through a configuration input. A capacity of zero means the pool has no limit.

Top module: `rename_pool_tracker`

## Requirements
- R1: Pool 0 is charged the cost of every valid allocation and release, whatever pool index the lane carries. A lane whose index p lies in 1..NUM_POOLS-1 is also charged to pool p. A lane with index 0, or with an index of NUM_POOLS or more, changes only pool 0.
- R2: Each lane changes a count by its full cost field (0..7), not by one. Several lanes that hit the same pool in one cycle add their costs together.
- R3: A pool whose capacity input is 0 has no limit. Its bit in `busy_mask` is always 0.
- R4: For a bounded pool p, bit p of `busy_mask` (bit position = pool index) is 1 exactly when used_p + need_p > cap_p. Here need_p is the summed cost of the valid query lanes that charge pool p under R1. The mask is combinational from the current counts and the query lanes.
- R5: If need_p exceeds cap_p, need_p is clamped to cap_p before the compare. A bounded pool with a count of 0 is therefore never busy, however large the query group is.
- R6: A lane whose no-register flag is set charges nothing. This holds for allocation, release and query lanes alike.
- R7: Allocations and releases in the same cycle combine. After the clock edge, `used_cnt` for pool p shows used_p + alloc_p - free_p. Pool p occupies `used_cnt` bits [p*CNT_W +: CNT_W].
- R8: If a pool's releases would take its count below zero, the count becomes 0 and `err_underflow` is set. The flag stays set until reset.
- R9: Synchronous active-high reset clears every count and the error flag.
- R10: A count that would pass 2^CNT_W-1 holds at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pool_cap | input | NUM_POOLS*CNT_W | Capacity of each pool; 0 means unbounded |
| alc_vld | input | N_ALLOC | Allocation lane valid |
| alc_nophys | input | N_ALLOC | Allocation lane needs no physical register |
| alc_pool | input | N_ALLOC*PIDX_W | Allocation lane pool index |
| alc_cost | input | N_ALLOC*COST_W | Allocation lane cost |
| rel_vld | input | N_FREE | Release lane valid |
| rel_nophys | input | N_FREE | Release lane held no physical register |
| rel_pool | input | N_FREE*PIDX_W | Release lane pool index |
| rel_cost | input | N_FREE*COST_W | Release lane cost |
| qry_vld | input | N_QUERY | Query lane valid |
| qry_nophys | input | N_QUERY | Query lane needs no physical register |
| qry_pool | input | N_QUERY*PIDX_W | Query lane pool index |
| qry_cost | input | N_QUERY*COST_W | Query lane cost |
| busy_mask | output | NUM_POOLS | One bit per pool that cannot accept the query group |
| used_cnt | output | NUM_POOLS*CNT_W | Current count of each pool |
| err_underflow | output | 1 | Sticky release-underflow flag |

## Verification
The availability check is swept with a single query lane over every pool index and every cost, starting from a known occupancy. This separates the global-only charging of index 0 and the out-of-range index from the charging of a real pool. It also shows the exact threshold where used plus need first exceeds capacity.

Oversized query groups are applied against an empty pool and then against a pool holding one register. This separates the clamped result from an unclamped compare.

Directed steps then cover combined allocate and release cycles, lanes flagged as needing no register, an underflowing release, and a climb to the top of the counter. These show that saturation works at both ends and that the error flag is sticky.

A long pseudo-random mix of several lanes is checked against an arithmetic model, with one pool left unbounded.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
    // Width of a pool index on every lane.
    localparam int PIDX_W = 2;
    // Width of a per-lane cost in physical registers.
    localparam int COST_W = 3;

    // One allocation, release or query lane.
    typedef struct packed {
        logic              vld;
        logic              nophys;
        logic [PIDX_W-1:0] pool;
        logic [COST_W-1:0] cost;
    } req_t;

    // Cost that lane r charges to pool p. The global pool 0 takes every
    // charge; any other pool takes only lanes that name it.
    function automatic logic [COST_W-1:0] charge(req_t r, int p);
        if (!r.vld || r.nophys)
            return '0;
        if (p == 0)
            return r.cost;
        if (r.pool == PIDX_W'(p))
            return r.cost;
        return '0;
    endfunction
endpackage

// File: rtl/rpt_demand_sum.sv
module rpt_demand_sum
    import rpt_pkg::*;
#(
    parameter int N_LANES = 2,
    parameter int N_POOLS = 3,
    parameter int SUM_W   = 5
) (
    input  req_t             lanes [N_LANES],
    output logic [SUM_W-1:0] total [N_POOLS]
);
    // One adder tree per pool over every lane.
    for (genvar p = 0; p < N_POOLS; p++) begin : g_pool
        logic [SUM_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int i = 0; i < N_LANES; i++)
                acc = acc + SUM_W'(charge(lanes[i], p));
        end
        assign total[p] = acc;
    end
endmodule

// File: rtl/rpt_pool_counter.sv
module rpt_pool_counter #(
    parameter int CNT_W = 8,
    parameter int SUM_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SUM_W-1:0] add,
    input  logic [SUM_W-1:0] sub,
    output logic [CNT_W-1:0] used,
    output logic             uflow
);
    localparam int WW = ((CNT_W > SUM_W) ? CNT_W : SUM_W) + 1;
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [WW-1:0] grow;
    logic [WW-1:0] net;

    always_comb begin
        grow  = WW'(used) + WW'(add);
        uflow = grow < WW'(sub);
        net   = grow - WW'(sub);
    end

    always_ff @(posedge clk) begin
        if (rst)
            used <= '0;
        else if (uflow)
            used <= '0;
        else if (net > WW'(MAXV))
            used <= MAXV;
        else
            used <= net[CNT_W-1:0];
    end

    // R8
    floor_chk: assert property (@(posedge clk) disable iff (rst)
        (WW'(sub) > WW'(used) + WW'(add)) |=> (used == '0));

    // R10
    ceiling_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (used == MAXV && sub == '0) |=> (used == MAXV));

    // R7
    net_move_chk: assert property (@(posedge clk) disable iff (rst)
        (sub == '0 && add == '0) |=> $stable(used));
endmodule

// File: rtl/rpt_avail_check.sv
module rpt_avail_check #(
    parameter int CNT_W = 8,
    parameter int SUM_W = 5
) (
    input  logic [CNT_W-1:0] cap,
    input  logic [CNT_W-1:0] used,
    input  logic [SUM_W-1:0] need,
    output logic             busy
);
    localparam int WW = ((CNT_W > SUM_W) ? CNT_W : SUM_W) + 1;

    logic [WW-1:0] need_c;

    always_comb begin
        // Clamp an oversized request to the pool's capacity.
        need_c = (WW'(need) > WW'(cap)) ? WW'(cap) : WW'(need);
        busy   = (cap != '0) && ((WW'(used) + need_c) > WW'(cap));
    end
endmodule

// File: rtl/rename_pool_tracker.sv
module rename_pool_tracker
    import rpt_pkg::*;
#(
    parameter int NUM_POOLS = 3,
    parameter int N_ALLOC   = 2,
    parameter int N_FREE    = 2,
    parameter int N_QUERY   = 4,
    parameter int CNT_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_POOLS*CNT_W-1:0]  pool_cap,
    input  logic [N_ALLOC-1:0]          alc_vld,
    input  logic [N_ALLOC-1:0]          alc_nophys,
    input  logic [N_ALLOC*PIDX_W-1:0]   alc_pool,
    input  logic [N_ALLOC*COST_W-1:0]   alc_cost,
    input  logic [N_FREE-1:0]           rel_vld,
    input  logic [N_FREE-1:0]           rel_nophys,
    input  logic [N_FREE*PIDX_W-1:0]    rel_pool,
    input  logic [N_FREE*COST_W-1:0]    rel_cost,
    input  logic [N_QUERY-1:0]          qry_vld,
    input  logic [N_QUERY-1:0]          qry_nophys,
    input  logic [N_QUERY*PIDX_W-1:0]   qry_pool,
    input  logic [N_QUERY*COST_W-1:0]   qry_cost,
    output logic [NUM_POOLS-1:0]        busy_mask,
    output logic [NUM_POOLS*CNT_W-1:0]  used_cnt,
    output logic                        err_underflow
);
    localparam int LANE_MAX = (N_ALLOC > N_FREE)
                              ? ((N_ALLOC > N_QUERY) ? N_ALLOC : N_QUERY)
                              : ((N_FREE > N_QUERY) ? N_FREE : N_QUERY);
    localparam int SUM_W = COST_W + $clog2(LANE_MAX + 1);
    localparam int WW    = ((CNT_W > SUM_W) ? CNT_W : SUM_W) + 1;

    req_t alc_req [N_ALLOC];
    req_t rel_req [N_FREE];
    req_t qry_req [N_QUERY];

    logic [SUM_W-1:0] add_sum  [NUM_POOLS];
    logic [SUM_W-1:0] sub_sum  [NUM_POOLS];
    logic [SUM_W-1:0] need_sum [NUM_POOLS];
    logic [CNT_W-1:0] cap_a    [NUM_POOLS];
    logic [CNT_W-1:0] used_a   [NUM_POOLS];
    logic [NUM_POOLS-1:0] uflow_v;
    logic err_q;

    // Unpack the flat lane ports into lane records.
    for (genvar i = 0; i < N_ALLOC; i++) begin : g_alc
        assign alc_req[i] = '{vld: alc_vld[i], nophys: alc_nophys[i],
                              pool: alc_pool[i*PIDX_W +: PIDX_W],
                              cost: alc_cost[i*COST_W +: COST_W]};
    end
    for (genvar i = 0; i < N_FREE; i++) begin : g_rel
        assign rel_req[i] = '{vld: rel_vld[i], nophys: rel_nophys[i],
                              pool: rel_pool[i*PIDX_W +: PIDX_W],
                              cost: rel_cost[i*COST_W +: COST_W]};
    end
    for (genvar i = 0; i < N_QUERY; i++) begin : g_qry
        assign qry_req[i] = '{vld: qry_vld[i], nophys: qry_nophys[i],
                              pool: qry_pool[i*PIDX_W +: PIDX_W],
                              cost: qry_cost[i*COST_W +: COST_W]};
    end

    rpt_demand_sum #(.N_LANES(N_ALLOC), .N_POOLS(NUM_POOLS), .SUM_W(SUM_W))
        u_alc_sum (.lanes(alc_req), .total(add_sum));
    rpt_demand_sum #(.N_LANES(N_FREE), .N_POOLS(NUM_POOLS), .SUM_W(SUM_W))
        u_rel_sum (.lanes(rel_req), .total(sub_sum));
    rpt_demand_sum #(.N_LANES(N_QUERY), .N_POOLS(NUM_POOLS), .SUM_W(SUM_W))
        u_qry_sum (.lanes(qry_req), .total(need_sum));

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        assign cap_a[p] = pool_cap[p*CNT_W +: CNT_W];

        rpt_pool_counter #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .add   (add_sum[p]),
            .sub   (sub_sum[p]),
            .used  (used_a[p]),
            .uflow (uflow_v[p])
        );

        rpt_avail_check #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_chk (
            .cap  (cap_a[p]),
            .used (used_a[p]),
            .need (need_sum[p]),
            .busy (busy_mask[p])
        );

        assign used_cnt[p*CNT_W +: CNT_W] = used_a[p];

        // R3
        unbounded_chk: assert property (@(posedge clk) disable iff (rst)
            (cap_a[p] == '0) |-> !busy_mask[p]);

        // R5
        empty_fits_chk: assert property (@(posedge clk) disable iff (rst)
            (cap_a[p] != '0 && used_a[p] == '0) |-> !busy_mask[p]);

        // R4
        busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
            busy_mask[p] |-> ((WW'(used_a[p]) + WW'(need_sum[p])) > WW'(cap_a[p])));

        // R1
        if (p != 0) begin : g_glob
            global_cover_chk: assert property (@(posedge clk) disable iff (rst)
                (add_sum[p] <= add_sum[0]) && (sub_sum[p] <= sub_sum[0]));
        end
    end

    // Sticky underflow flag.
    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (|uflow_v)
            err_q <= 1'b1;
    end
    assign err_underflow = err_q;

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_underflow |=> err_underflow);

    // R6
    quiet_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|(alc_vld & ~alc_nophys)) && !(|(rel_vld & ~rel_nophys)))
        |=> $stable(used_cnt));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (used_cnt == '0 && !err_underflow));
endmodule

// File: tb/test_rename_pool_tracker.sv
module test_rename_pool_tracker;
    localparam int NP = 3;
    localparam int NA = 2;
    localparam int NF = 2;
    localparam int NQ = 4;
    localparam int CW = 8;
    localparam int MAXV = 255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NP*CW-1:0] pool_cap;
    logic [NA-1:0] alc_vld, alc_nophys;
    logic [NA*2-1:0] alc_pool;
    logic [NA*3-1:0] alc_cost;
    logic [NF-1:0] rel_vld, rel_nophys;
    logic [NF*2-1:0] rel_pool;
    logic [NF*3-1:0] rel_cost;
    logic [NQ-1:0] qry_vld, qry_nophys;
    logic [NQ*2-1:0] qry_pool;
    logic [NQ*3-1:0] qry_cost;
    logic [NP-1:0] busy_mask;
    logic [NP*CW-1:0] used_cnt;
    logic err_underflow;

    // Bench-side lane arrays.
    logic a_v [NA]; logic a_n [NA]; logic [1:0] a_p [NA]; logic [2:0] a_c [NA];
    logic f_v [NF]; logic f_n [NF]; logic [1:0] f_p [NF]; logic [2:0] f_c [NF];
    logic q_v [NQ]; logic q_n [NQ]; logic [1:0] q_p [NQ]; logic [2:0] q_c [NQ];
    int m_cap [NP];
    int m_used [NP];
    bit m_err;

    int checks = 0;
    int errs = 0;
    bit done = 0;
    logic [15:0] lf = 16'hACE1;

    always_comb begin
        for (int i = 0; i < NA; i++) begin
            alc_vld[i] = a_v[i]; alc_nophys[i] = a_n[i];
            alc_pool[i*2 +: 2] = a_p[i]; alc_cost[i*3 +: 3] = a_c[i];
        end
        for (int i = 0; i < NF; i++) begin
            rel_vld[i] = f_v[i]; rel_nophys[i] = f_n[i];
            rel_pool[i*2 +: 2] = f_p[i]; rel_cost[i*3 +: 3] = f_c[i];
        end
        for (int i = 0; i < NQ; i++) begin
            qry_vld[i] = q_v[i]; qry_nophys[i] = q_n[i];
            qry_pool[i*2 +: 2] = q_p[i]; qry_cost[i*3 +: 3] = q_c[i];
        end
        for (int p = 0; p < NP; p++) pool_cap[p*CW +: CW] = CW'(m_cap[p]);
    end

    rename_pool_tracker i_rename_pool_tracker (
        .clk(clk), .rst(rst), .pool_cap(pool_cap),
        .alc_vld(alc_vld), .alc_nophys(alc_nophys), .alc_pool(alc_pool), .alc_cost(alc_cost),
        .rel_vld(rel_vld), .rel_nophys(rel_nophys), .rel_pool(rel_pool), .rel_cost(rel_cost),
        .qry_vld(qry_vld), .qry_nophys(qry_nophys), .qry_pool(qry_pool), .qry_cost(qry_cost),
        .busy_mask(busy_mask), .used_cnt(used_cnt), .err_underflow(err_underflow)
    );

    function automatic int chg(logic v, logic n, logic [1:0] pl, logic [2:0] c, int p);
        if (!v || n) return 0;
        if (p == 0 || int'(pl) == p) return int'(c);
        return 0;
    endfunction

    function automatic logic [NP-1:0] exp_mask();
        logic [NP-1:0] m;
        for (int p = 0; p < NP; p++) begin
            int need = 0;
            for (int i = 0; i < NQ; i++) need += chg(q_v[i], q_n[i], q_p[i], q_c[i], p);
            if (need > m_cap[p]) need = m_cap[p];
            m[p] = (m_cap[p] != 0) && (m_used[p] + need > m_cap[p]);
        end
        return m;
    endfunction

    task automatic clear_lanes();
        for (int i = 0; i < NA; i++) begin a_v[i] = 0; a_n[i] = 0; a_p[i] = 0; a_c[i] = 0; end
        for (int i = 0; i < NF; i++) begin f_v[i] = 0; f_n[i] = 0; f_p[i] = 0; f_c[i] = 0; end
        for (int i = 0; i < NQ; i++) begin q_v[i] = 0; q_n[i] = 0; q_p[i] = 0; q_c[i] = 0; end
    endtask

    task automatic check_mask(string tag);
        logic [NP-1:0] e;
        #1;
        e = exp_mask();
        checks++;
        if (busy_mask !== e) begin
            errs++;
            $display("FAIL %s busy_mask: actual=%b expected=%b", tag, busy_mask, e);
        end
    endtask

    // Apply the current alloc/release lanes across one clock edge.
    task automatic tick(string tag);
        for (int p = 0; p < NP; p++) begin
            int add = 0, sub = 0, t;
            for (int i = 0; i < NA; i++) add += chg(a_v[i], a_n[i], a_p[i], a_c[i], p);
            for (int i = 0; i < NF; i++) sub += chg(f_v[i], f_n[i], f_p[i], f_c[i], p);
            t = m_used[p] + add;
            if (t < sub) begin m_used[p] = 0; m_err = 1; end
            else begin m_used[p] = t - sub; if (m_used[p] > MAXV) m_used[p] = MAXV; end
        end
        @(posedge clk); #1;
        for (int p = 0; p < NP; p++) begin
            checks++;
            if (int'(used_cnt[p*CW +: CW]) != m_used[p]) begin
                errs++;
                $display("FAIL %s used[%0d]: actual=%0d expected=%0d", tag, p,
                         used_cnt[p*CW +: CW], m_used[p]);
            end
        end
        checks++;
        if (err_underflow !== m_err) begin
            errs++;
            $display("FAIL %s err_underflow: actual=%b expected=%b", tag, err_underflow, m_err);
        end
    endtask

    function automatic logic [15:0] step_lf(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R9 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        clear_lanes();
        m_cap[0] = 20; m_cap[1] = 4; m_cap[2] = 0;
        for (int p = 0; p < NP; p++) m_used[p] = 0;
        m_err = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R9: counts and flag clear after reset
        tick("R9");
        check_mask("R9");

        // R5: oversized query against empty pools is clamped and fits
        for (int i = 0; i < NQ; i++) begin q_v[i] = 1; q_p[i] = 1; q_c[i] = 7; end
        check_mask("R5");
        a_v[0] = 1; a_p[0] = 1; a_c[0] = 1;
        tick("R5");
        clear_lanes();
        for (int i = 0; i < NQ; i++) begin q_v[i] = 1; q_p[i] = 1; q_c[i] = 7; end
        check_mask("R5");
        clear_lanes();
        f_v[0] = 1; f_p[0] = 1; f_c[0] = 1;
        tick("R5");
        clear_lanes();

        // R1: named pool, pool 0 only, out-of-range index
        a_v[0] = 1; a_p[0] = 1; a_c[0] = 3; tick("R1");
        a_p[0] = 0; a_c[0] = 2; tick("R1");
        a_p[0] = 3; a_c[0] = 1; tick("R1");
        clear_lanes();

        // R2: two lanes with different costs in one cycle
        a_v[0] = 1; a_p[0] = 2; a_c[0] = 5;
        a_v[1] = 1; a_p[1] = 2; a_c[1] = 7;
        tick("R2");
        clear_lanes();

        // R6: no-register lanes change nothing
        a_v[0] = 1; a_n[0] = 1; a_p[0] = 1; a_c[0] = 7;
        f_v[0] = 1; f_n[0] = 1; f_p[0] = 2; f_c[0] = 6;
        tick("R6");
        clear_lanes();
        m_cap[1] = 8;
        q_v[0] = 1; q_n[0] = 1; q_p[0] = 1; q_c[0] = 7;
        check_mask("R6");
        clear_lanes();

        // R7: allocate and release together
        a_v[0] = 1; a_p[0] = 1; a_c[0] = 4;
        f_v[0] = 1; f_p[0] = 2; f_c[0] = 3;
        f_v[1] = 1; f_p[1] = 1; f_c[1] = 1;
        tick("R7");
        clear_lanes();

        // R4 / R3: single-lane sweep over every index and cost
        m_cap[0] = m_used[0] + 4; m_cap[1] = m_used[1] + 3; m_cap[2] = 0;
        for (int pl = 0; pl < 4; pl++)
            for (int c = 0; c < 8; c++) begin
                q_v[0] = 1; q_p[0] = 2'(pl); q_c[0] = 3'(c);
                if (pl == 2) check_mask("R3"); else check_mask("R4");
            end
        clear_lanes();

        // R8: release past zero floors the count and sets the sticky flag
        f_v[0] = 1; f_p[0] = 2; f_c[0] = 7;
        f_v[1] = 1; f_p[1] = 2; f_c[1] = 7;
        tick("R8");
        clear_lanes();
        tick("R8");

        // R10: climb to the top of the counter
        for (int k = 0; k < 22; k++) begin
            a_v[0] = 1; a_p[0] = 0; a_c[0] = 7;
            a_v[1] = 1; a_p[1] = 1; a_c[1] = 7;
            tick("R10");
        end
        clear_lanes();

        // R4: pseudo-random multi-lane mix, pool 2 unbounded
        m_cap[0] = 200; m_cap[1] = 60; m_cap[2] = 0;
        for (int k = 0; k < 300; k++) begin
            for (int i = 0; i < NA; i++) begin
                lf = step_lf(lf);
                a_v[i] = lf[0]; a_n[i] = lf[1] & lf[2]; a_p[i] = lf[4:3]; a_c[i] = lf[7:5];
                f_v[i] = lf[8]; f_n[i] = lf[9] & lf[10]; f_p[i] = lf[12:11]; f_c[i] = lf[15:13];
            end
            for (int i = 0; i < NQ; i++) begin
                lf = step_lf(lf);
                q_v[i] = lf[0]; q_n[i] = lf[1] & lf[2]; q_p[i] = lf[4:3]; q_c[i] = lf[7:5];
            end
            check_mask("R4");
            tick("R7");
        end
        clear_lanes();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule